// File: doc/BRIEF.md
# AES Fault Round Classifier

This block sorts pairs of AES-128 ciphertexts for a differential fault campaign. Each pair holds a known-good ciphertext and a ciphertext captured while the encryption was disturbed. The block XORs the two values and finds which bytes differ. From the placement of those bytes it decides whether the pair carries no fault, a fault in the last round, a single-byte fault that entered before the MixColumns step of round nine, a fault from an earlier round, or a pattern that no clean fault explains, such as a corrupted reply. A round-nine fault shows up as exactly four differing bytes. Because the final round has no MixColumns, those four bytes are the bytes that ShiftRows moves out of one state column, and the block reports that column as well.

Pairs arrive on a valid/ready handshake. The verdict is registered and appears one cycle after the pair is accepted. The block counts the round-nine pairs it accepts. When the count reaches a programmable target it raises a one-cycle done pulse, and it then refuses further pairs until a synchronous clear restarts collection. The usual target is 24 pairs.

Top module: `fault_round_classifier`

## Requirements
- R1: When `in_valid` and `in_ready` are both high at a rising edge, `res_valid` is high for exactly the following cycle and carries the verdict for that pair. In all other cycles `res_valid` is low.
- R2: Byte k of a ciphertext is bits [8k+7:8k], and byte index = 4*column + row. If the two ciphertexts are identical, `res_class` is 0.
- R3: If exactly one byte differs, `res_class` is 10.
- R4: If exactly four bytes differ and they form the set for column c, `res_class` is 9 and `res_col` is c. The sets are: column 0 = bytes {0,7,10,13}, column 1 = {1,4,11,14}, column 2 = {2,5,8,15}, column 3 = {3,6,9,12}.
- R5: If all sixteen bytes differ, `res_class` is 8.
- R6: Every other pattern gives `res_class` 15. This includes four bytes that match no column set, two bytes, the union of two column sets, and fifteen bytes.
- R7: `res_col` is 0 whenever `res_class` is not 9.
- R8: `pair_count` rises by one at the edge that accepts a pair classified 9. Accepted pairs of any other class leave it unchanged.
- R9: `in_ready` is low while `pair_count` is at or above `target`. A pair offered while `in_ready` is low produces no result and does not change the count.
- R10: `done` is high for one cycle, in the cycle in which `pair_count` first equals `target`.
- R11: When `clr` is high at an edge, `pair_count` becomes 0 at that edge, even if a round-nine pair is accepted at the same edge. That pair is still classified.
- R12: While `rst` is high, and right after it, `res_valid`, `done` and `pair_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the pair counter |
| target | input | CNT_W | Number of round-nine pairs to collect |
| in_valid | input | 1 | Pair offered |
| in_ready | output | 1 | Pair can be accepted |
| ref_ct | input | 128 | Known-good ciphertext |
| test_ct | input | 128 | Ciphertext under test |
| res_valid | output | 1 | Verdict valid |
| res_class | output | 4 | Class code 0, 8, 9, 10 or 15 |
| res_col | output | 2 | Fault column for class 9 |
| pair_count | output | CNT_W | Accepted round-nine pairs |
| done | output | 1 | Target reached pulse |

## Verification
The classifier has no state, so a wrong signature table or a wrong byte order shows up on the very next verdict as a wrong class or a wrong column. The bench therefore sends every column set and several near-miss patterns. A counter that drifts shows up in the cycle after the accepting edge. It appears as a wrong `pair_count`, as a `done` pulse that comes early, late or not at all, or as `in_ready` staying high beyond the target. The bench reads all of these right after every round-nine pair, after a clear, and while it offers pairs to a full collector.

// File: rtl/fcls_pkg.sv
package fcls_pkg;
  localparam int NBYTES = 16;
  localparam int NCOLS  = 4;

  typedef enum logic [3:0] {
    CLS_SAME  = 4'd0,
    CLS_EARLY = 4'd8,
    CLS_R9    = 4'd9,
    CLS_R10   = 4'd10,
    CLS_BAD   = 4'd15
  } cls_e;

  // Bytes touched by a round-nine fault in state column c:
  // row r of the column lands on byte (4c + 13r) mod 16 after ShiftRows.
  function automatic logic [NBYTES-1:0] col_signature(input int c);
    logic [NBYTES-1:0] m;
    m = '0;
    for (int r = 0; r < 4; r++) m[(4*c + 13*r) % NBYTES] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/byte_diff.sv
module byte_diff #(
  parameter int NB = 16
) (
  input  logic [8*NB-1:0] a,
  input  logic [8*NB-1:0] b,
  output logic [NB-1:0]   mask
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign mask[i] = |(a[8*i +: 8] ^ b[8*i +: 8]);
  end
endmodule

// File: rtl/sig_match.sv
module sig_match
  import fcls_pkg::*;
(
  input  logic [NBYTES-1:0] mask,
  output cls_e              cls,
  output logic [1:0]        col
);
  localparam int PW = $clog2(NBYTES + 1);

  logic [NCOLS-1:0] hit;
  logic [PW-1:0]    pop;

  for (genvar c = 0; c < NCOLS; c++) begin : g_sig
    localparam logic [NBYTES-1:0] SIG = col_signature(c);
    assign hit[c] = (mask == SIG);
  end

  assign pop = PW'($countones(mask));

  always_comb begin
    cls = CLS_BAD;
    col = '0;
    if (pop == '0)                    cls = CLS_SAME;
    else if (pop == PW'(1))           cls = CLS_R10;
    else if (pop == PW'(NBYTES))      cls = CLS_EARLY;
    else if (|hit) begin
      cls = CLS_R9;
      for (int c = 0; c < NCOLS; c++)
        if (hit[c]) col = 2'(c);
    end
  end
endmodule

// File: rtl/pair_tally.sv
module pair_tally #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bump,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic             full
);
  logic [CNT_W-1:0] nxt;
  assign nxt  = count + CNT_W'(1);
  assign full = (count >= target);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        count <= '0;
      end else if (bump) begin
        count <= nxt;
        if (nxt == target) done <= 1'b1;
      end
    end
  end

  // R8: each round-nine acceptance advances the count by exactly one
  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    (bump && !clr) |=> count == $past(count) + CNT_W'(1));
  // R11: clear zeroes the count
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);
  // R10: done only appears with a nonzero count
  a_r10_done_nonzero: assert property (@(posedge clk) disable iff (rst)
    done |-> count != '0);
endmodule

// File: rtl/fault_round_classifier.sv
module fault_round_classifier
  import fcls_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CNT_W-1:0] target,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [127:0]     ref_ct,
  input  logic [127:0]     test_ct,
  output logic             res_valid,
  output logic [3:0]       res_class,
  output logic [1:0]       res_col,
  output logic [CNT_W-1:0] pair_count,
  output logic             done
);
  logic [NBYTES-1:0] mask;
  cls_e              cls_c;
  logic [1:0]        col_c;
  logic              accept, full;

  byte_diff #(.NB(NBYTES)) u_diff (
    .a(ref_ct), .b(test_ct), .mask(mask)
  );

  sig_match u_match (
    .mask(mask), .cls(cls_c), .col(col_c)
  );

  assign in_ready = !full;
  assign accept   = in_valid && in_ready;

  pair_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .clr(clr),
    .bump(accept && (cls_c == CLS_R9)),
    .target(target), .count(pair_count), .done(done), .full(full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_class <= 4'd0;
      res_col   <= 2'd0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        res_class <= cls_c;
        res_col   <= col_c;
      end
    end
  end

  // R1: a verdict follows every accepted pair, and only those
  a_r1_result_next: assert property (@(posedge clk) disable iff (rst)
    accept |=> res_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !res_valid);
  // R7: the column is zero outside class 9
  a_r7_col_zero: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class != 4'd9) |-> res_col == 2'd0);
  // R9: a full collector holds its count
  a_r9_hold_full: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !clr) |=> $stable(pair_count));
  // R10: done coincides with the count reaching target
  a_r10_done_at_target: assert property (@(posedge clk) disable iff (rst)
    done |-> pair_count == $past(target));
endmodule

// File: tb/fault_round_classifier_test.sv
module fault_round_classifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           clr = 1'b0;
  logic [CW-1:0]  target = 8'd3;
  logic           in_valid = 1'b0;
  logic [127:0]   ref_ct = '0;
  logic [127:0]   test_ct = '0;
  logic           in_ready, res_valid, done;
  logic [3:0]     res_class;
  logic [1:0]     res_col;
  logic [CW-1:0]  pair_count;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 1'b0;
  logic [5:0] expq[$];
  string      tagq[$];

  fault_round_classifier #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .clr(clr), .target(target),
    .in_valid(in_valid), .in_ready(in_ready),
    .ref_ct(ref_ct), .test_ct(test_ct),
    .res_valid(res_valid), .res_class(res_class), .res_col(res_col),
    .pair_count(pair_count), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard as verdicts appear
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (expq.size() == 0) begin
        chk("R1 unexpected verdict", 1, 0);
      end else begin
        logic [5:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk({t, " class"}, int'(res_class), int'(e[5:2]));
        chk({t, " column"}, int'(res_col), int'(e[1:0]));
      end
    end
  end

  // Driver: builds a pair whose differing bytes follow mask m
  task automatic send(input string tag, input logic [15:0] m,
                      input logic [3:0] ec, input logic [1:0] ecol,
                      input bit expect_accept);
    logic [127:0] r, t;
    r = {$urandom, $urandom, $urandom, $urandom};
    t = r;
    for (int i = 0; i < 16; i++)
      if (m[i]) t[8*i +: 8] = r[8*i +: 8] ^ (8'h11 + 8'(i));
    if (expect_accept) begin
      expq.push_back({ec, ecol});
      tagq.push_back(tag);
    end
    ref_ct   = r;
    test_ct  = t;
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12 res_valid in reset", int'(res_valid), 0);
    chk("R12 done in reset", int'(done), 0);
    chk("R12 pair_count in reset", int'(pair_count), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R12 pair_count after reset", int'(pair_count), 0);
    chk("R9 ready when empty", int'(in_ready), 1);

    send("R2 identical", 16'h0000, 4'd0, 2'd0, 1'b1);
    send("R3 byte 5", 16'h0020, 4'd10, 2'd0, 1'b1);
    send("R3 byte 15", 16'h8000, 4'd10, 2'd0, 1'b1);
    send("R4 column 0", 16'h2481, 4'd9, 2'd0, 1'b1);
    chk("R8 count after first", int'(pair_count), 1);
    send("R5 all bytes", 16'hFFFF, 4'd8, 2'd0, 1'b1);
    send("R6 four off-signature", 16'h000F, 4'd15, 2'd0, 1'b1);
    send("R6 two bytes", 16'h0101, 4'd15, 2'd0, 1'b1);
    send("R6 two columns", 16'h6C93, 4'd15, 2'd0, 1'b1);
    send("R6 fifteen bytes", 16'h7FFF, 4'd15, 2'd0, 1'b1);
    chk("R8 count unchanged by non-9", int'(pair_count), 1);
    send("R4 column 2", 16'h8124, 4'd9, 2'd2, 1'b1);
    chk("R8 count after second", int'(pair_count), 2);
    chk("R10 no early done", int'(done), 0);
    send("R4 column 3", 16'h1248, 4'd9, 2'd3, 1'b1);
    chk("R8 count at target", int'(pair_count), 3);
    chk("R10 done pulse", int'(done), 1);
    @(posedge clk); #1;
    chk("R10 done falls", int'(done), 0);
    chk("R9 ready low when full", int'(in_ready), 0);

    send("R9 ignored while full", 16'h4812, 4'd9, 2'd1, 1'b0);
    @(posedge clk); #1;
    chk("R9 count held while full", int'(pair_count), 3);

    clr = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0;
    chk("R11 clear zeroes count", int'(pair_count), 0);
    chk("R11 ready after clear", int'(in_ready), 1);

    clr = 1'b1;
    send("R11 pair during clear", 16'h4812, 4'd9, 2'd1, 1'b1);
    clr = 1'b0;
    chk("R11 clear beats bump", int'(pair_count), 0);

    send("R4 column 1", 16'h4812, 4'd9, 2'd1, 1'b1);
    chk("R8 count after restart", int'(pair_count), 1);

    repeat (3) @(posedge clk); #1;
    chk("R1 all verdicts seen", expq.size(), 0);
    finish_up();
  end
endmodule